// File: doc/BRIEF.md
# Fractional UART Baud Rate Generator

This block turns a reference clock into the timing strobes that a UART transmitter and receiver need. Software programs a 16-bit integer divisor, a 4-bit fraction counted in sixteenths, an oversampling ratio of 16, 8 or 4, and an optional divide-by-4 input prescaler through a small byte-wide register port. The block then produces a one-clock `sample_tick` at the oversampling rate and a `bit_tick` that marks every Nth sample tick, where N is the selected ratio. The resulting bit rate is the prescaled clock divided by the divisor and by the oversampling ratio.

The fraction is applied by a 4-bit phase accumulator. At the end of each divider period the fraction is added to the accumulator, and a carry out lengthens the next period by one prescaled clock. Over sixteen periods the average divisor is therefore D + F/16. Any register write restarts every counter, so that a new setting takes effect from a known phase. A zero integer divisor halts both strobes and drops `div_nonzero`, which power-management logic can use to judge whether the port is idle.

Top module: `frac_baud_gen`

## Requirements
- R1: After reset, every register reads 0x00. This means divisor 0, fraction 0, 16x sampling and prescale by 1. `div_nonzero` is low and no tick is produced.
- R2: Register map (`wr_addr`/`rd_addr`): address 0 holds divisor bits 7:0 and address 1 holds divisor bits 15:8. Address 2 holds the fraction in bits 3:0 and the sampling select in bits 5:4. Address 3 holds the prescaler select in bit 0. Every written field reads back unchanged.
- R3: Bits 7:6 of address 2 always read 0, and writing ones to them changes nothing else.
- R4: With fraction 0 and prescale by 1, consecutive sample ticks are exactly D clocks apart.
- R5: With fraction F, the k-th divider period after a restart lasts D + c_k prescaled clocks. Here c_1 = 0, and c_(k+1) is the carry out of a 4-bit accumulator that starts at 0 and has F added at the end of each period.
- R6: Prescaler select 1 (address 3 bit 0) scales every divider period by 4 clocks per prescaled clock. Select 0 scales it by 1.
- R7: Sampling select 00 gives N = 16, 01 gives N = 8, and both 10 and 11 give N = 4. `bit_tick` is high together with the Nth, 2Nth, ... sample tick counted from the last restart.
- R8: While the integer divisor is 0, `div_nonzero` is low and neither tick is produced.
- R9: A write to any register restarts the prescaler, divider, accumulator and tick count. The first sample tick afterwards is seen 1 + P*D clock edges after the edge that takes the write.
- R10: `bit_tick` is never high without `sample_tick`, and two bit ticks never fall on consecutive clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| sample_tick | output | 1 | One-clock strobe at the oversampling rate |
| bit_tick | output | 1 | Strobe on every Nth sample tick |
| div_nonzero | output | 1 | High when the integer divisor is not zero |

## Verification
The assertions assume that the divisor, fraction and sampling select change only through the register port. Every such change raises the internal restart pulse, and the divider and tick-count bounds are only claimed outside that pulse. The stimulus only ever writes through `wr_en` and keeps `rst_n` low long enough for the internal synchronizer to settle. The bench arms its scoreboard only after the last write of a configuration, so that a tick computed from the old settings never enters a comparison.

// File: rtl/baud_pkg.sv
package baud_pkg;

  localparam int unsigned REG_ADDR_W = 2;
  localparam int unsigned REG_DATA_W = 8;
  localparam int unsigned MAX_OS     = 16;
  localparam int unsigned OS_CNT_W   = $clog2(MAX_OS);

  localparam logic [REG_ADDR_W-1:0] A_DIV_LO = 2'd0;
  localparam logic [REG_ADDR_W-1:0] A_DIV_HI = 2'd1;
  localparam logic [REG_ADDR_W-1:0] A_FRAC   = 2'd2;
  localparam logic [REG_ADDR_W-1:0] A_PRE    = 2'd3;

  typedef enum logic [1:0] {
    OS_X16 = 2'b00,
    OS_X8  = 2'b01,
    OS_X4  = 2'b10,
    OS_X4B = 2'b11
  } os_sel_e;

  function automatic logic [OS_CNT_W-1:0] os_last(input os_sel_e sel);
    case (sel)
      OS_X16:  os_last = OS_CNT_W'(15);
      OS_X8:   os_last = OS_CNT_W'(7);
      default: os_last = OS_CNT_W'(3);
    endcase
  endfunction

endpackage

// File: rtl/baud_cfg_regs.sv
module baud_cfg_regs
  import baud_pkg::*;
#(
  parameter int unsigned DIV_W  = 16,
  parameter int unsigned FRAC_W = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [REG_ADDR_W-1:0] wr_addr,
  input  logic [REG_DATA_W-1:0] wr_data,
  input  logic [REG_ADDR_W-1:0] rd_addr,
  output logic [REG_DATA_W-1:0] rd_data,
  output logic [DIV_W-1:0]      divisor,
  output logic [FRAC_W-1:0]     frac,
  output os_sel_e               os_sel,
  output logic                  pre_sel,
  output logic                  restart
);

  localparam int unsigned HI_W = DIV_W - REG_DATA_W;

  logic [REG_DATA_W-1:0] lo_q, lo_d;
  logic [HI_W-1:0]       hi_q, hi_d;
  logic [FRAC_W-1:0]     fr_q, fr_d;
  os_sel_e               os_q, os_d;
  logic                  pre_q, pre_d;
  logic                  rs_q;

  always_comb begin
    lo_d  = lo_q;
    hi_d  = hi_q;
    fr_d  = fr_q;
    os_d  = os_q;
    pre_d = pre_q;
    if (wr_en) begin
      case (wr_addr)
        A_DIV_LO: lo_d = wr_data;
        A_DIV_HI: hi_d = wr_data[HI_W-1:0];
        A_FRAC: begin
          fr_d = wr_data[FRAC_W-1:0];
          os_d = os_sel_e'(wr_data[5:4]);
        end
        default:  pre_d = wr_data[0];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q  <= '0;
      hi_q  <= '0;
      fr_q  <= '0;
      os_q  <= OS_X16;
      pre_q <= 1'b0;
      rs_q  <= 1'b0;
    end else begin
      lo_q  <= lo_d;
      hi_q  <= hi_d;
      fr_q  <= fr_d;
      os_q  <= os_d;
      pre_q <= pre_d;
      rs_q  <= wr_en;
    end
  end

  always_comb begin
    case (rd_addr)
      A_DIV_LO: rd_data = lo_q;
      A_DIV_HI: rd_data = REG_DATA_W'(hi_q);
      A_FRAC:   rd_data = {2'b00, os_q, 4'(fr_q)};
      default:  rd_data = {7'd0, pre_q};
    endcase
  end

  assign divisor = {hi_q, lo_q};
  assign frac    = fr_q;
  assign os_sel  = os_q;
  assign pre_sel = pre_q;
  assign restart = rs_q;

  // R3: reserved field of the fraction register never reads as one
  p_rsv_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == A_FRAC) |-> (rd_data[7:6] == 2'b00));

  // R9: a write is always followed by a restart pulse
  p_wr_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> restart);

endmodule

// File: rtl/baud_prescaler.sv
module baud_prescaler #(
  parameter int unsigned PRE_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pre_sel,
  input  logic restart,
  output logic en
);

  localparam int unsigned PW = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(PRE_DIV - 1);

  logic [PW-1:0] cnt_q, cnt_d;
  logic          wrap;

  assign wrap = (cnt_q == LAST);

  always_comb begin
    if (restart || !pre_sel) cnt_d = '0;
    else if (wrap)           cnt_d = '0;
    else                     cnt_d = cnt_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign en = !restart && (pre_sel ? wrap : 1'b1);

  // R6: with the divide-by-4 selected, enables never arrive back to back
  p_pre_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_sel && en) |=> (!en || !pre_sel));

  // R9: no enable during the restart cycle
  p_pre_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    restart |-> !en);

endmodule

// File: rtl/baud_frac_div.sv
module baud_frac_div #(
  parameter int unsigned DIV_W  = 16,
  parameter int unsigned FRAC_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  divisor,
  input  logic [FRAC_W-1:0] frac,
  input  logic              en,
  input  logic              restart,
  output logic              tick,
  output logic              active
);

  logic [DIV_W-1:0]  cnt_q, cnt_d;
  logic [FRAC_W-1:0] acc_q, acc_d;
  logic [FRAC_W:0]   sum;
  logic              tick_q, tick_d;

  assign active = |divisor;
  assign sum    = {1'b0, acc_q} + {1'b0, frac};

  always_comb begin
    cnt_d  = cnt_q;
    acc_d  = acc_q;
    tick_d = 1'b0;
    if (restart || !active) begin
      cnt_d = active ? (divisor - DIV_W'(1)) : '0;
      acc_d = '0;
    end else if (en) begin
      if (cnt_q == '0) begin
        tick_d = 1'b1;
        acc_d  = sum[FRAC_W-1:0];
        cnt_d  = divisor - DIV_W'(1) + DIV_W'(sum[FRAC_W]);
      end else begin
        cnt_d  = cnt_q - DIV_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      acc_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      acc_q  <= acc_d;
      tick_q <= tick_d;
    end
  end

  assign tick = tick_q;

  // R8: a zero divisor yields no tick on the next clock
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !tick);

  // R9: the cycle following a restart carries no tick
  p_restart_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !tick);

  // R5: a stretched period is at most one count longer than the divisor
  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !restart) |-> (cnt_q <= divisor));

endmodule

// File: rtl/baud_os_count.sv
module baud_os_count
  import baud_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  os_sel_e os_sel,
  input  logic    tick,
  input  logic    restart,
  output logic    bit_tick
);

  logic [OS_CNT_W-1:0] cnt_q, cnt_d;
  logic [OS_CNT_W-1:0] last;
  logic                at_last;

  assign last    = os_last(os_sel);
  assign at_last = (cnt_q == last);

  always_comb begin
    if (restart)           cnt_d = '0;
    else if (!tick)        cnt_d = cnt_q;
    else if (at_last)      cnt_d = '0;
    else                   cnt_d = cnt_q + OS_CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign bit_tick = tick && at_last && !restart;

  // R7: the sample count stays inside the selected ratio
  p_os_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !restart |-> (cnt_q <= last));

  // R10: bit ticks are never adjacent
  p_bit_spacing_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |=> !bit_tick);

endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
  import baud_pkg::*;
#(
  parameter int unsigned DIV_W   = 16,
  parameter int unsigned FRAC_W  = 4,
  parameter int unsigned PRE_DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [1:0] rd_addr,
  output logic [7:0] rd_data,
  output logic       sample_tick,
  output logic       bit_tick,
  output logic       div_nonzero
);

  logic [1:0]        rst_sync_q;
  logic              srst_n;
  logic [DIV_W-1:0]  divisor;
  logic [FRAC_W-1:0] frac;
  os_sel_e           os_sel;
  logic              pre_sel;
  logic              restart;
  logic              pre_en;
  logic              tick;
  logic              active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign srst_n = rst_sync_q[1];

  baud_cfg_regs #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) u_regs (
    .clk     (clk),
    .rst_n   (srst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .divisor (divisor),
    .frac    (frac),
    .os_sel  (os_sel),
    .pre_sel (pre_sel),
    .restart (restart)
  );

  baud_prescaler #(.PRE_DIV(PRE_DIV)) u_pre (
    .clk     (clk),
    .rst_n   (srst_n),
    .pre_sel (pre_sel),
    .restart (restart),
    .en      (pre_en)
  );

  baud_frac_div #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) u_div (
    .clk     (clk),
    .rst_n   (srst_n),
    .divisor (divisor),
    .frac    (frac),
    .en      (pre_en),
    .restart (restart),
    .tick    (tick),
    .active  (active)
  );

  baud_os_count u_os (
    .clk      (clk),
    .rst_n    (srst_n),
    .os_sel   (os_sel),
    .tick     (tick),
    .restart  (restart),
    .bit_tick (bit_tick)
  );

  assign sample_tick = tick;
  assign div_nonzero = active;

  // R10: a bit tick is only ever issued together with a sample tick
  p_bit_in_sample_r10: assert property (@(posedge clk) disable iff (!srst_n)
    bit_tick |-> sample_tick);

  // R8: status falling means the strobes stop on the following clock
  p_status_drop_r8: assert property (@(posedge clk) disable iff (!srst_n)
    !div_nonzero |=> !sample_tick && !bit_tick);

endmodule

// File: tb/tb_frac_baud_gen.sv
module tb_frac_baud_gen;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic [1:0] rd_addr = 2'd0;
  logic [7:0] rd_data;
  logic       sample_tick, bit_tick, div_nonzero;

  frac_baud_gen dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .sample_tick(sample_tick), .bit_tick(bit_tick), .div_nonzero(div_nonzero)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // ---------------- scoreboard ----------------
  int  exp_q[$];
  bit  mon_on = 0;
  bit  have_last = 0;
  int  last_cyc = 0;
  int  cyc_n = 0;
  int  ticks_seen = 0;
  int  mon_ratio = 16;

  always @(negedge clk) begin
    cyc_n = cyc_n + 1;
    if (mon_on) begin
      if (bit_tick && !sample_tick) check(0, "R10 bit without sample", 1, 0);
      if (sample_tick) begin
        ticks_seen = ticks_seen + 1;
        check(bit_tick == ((ticks_seen % mon_ratio) == 0), "R7 bit_tick phase",
              int'(bit_tick), int'((ticks_seen % mon_ratio) == 0));
        if (have_last && exp_q.size() > 0) begin
          int e;
          e = exp_q.pop_front();
          check((cyc_n - last_cyc) == e, "R4/R5/R6 tick interval", cyc_n - last_cyc, e);
        end
        have_last = 1;
        last_cyc = cyc_n;
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  // driver: configure, then push the intervals the requirements predict
  task automatic run_cfg(input int dv, input int f, input logic [7:0] frac_byte,
                         input int pre, input int ratio, input int nint);
    logic [4:0] acc;
    int p;
    mon_on = 0;
    wr(2'd0, dv[7:0]);
    wr(2'd1, dv[15:8]);
    wr(2'd2, frac_byte);
    exp_q.delete();
    have_last = 0;
    ticks_seen = 0;
    mon_ratio = ratio;
    p = pre ? 4 : 1;
    acc = 5'd0;
    for (int k = 0; k < nint; k++) begin
      acc = {1'b0, acc[3:0]} + 5'(f);
      exp_q.push_back(p * (dv + int'(acc[4])));
    end
    wr(2'd3, pre[7:0]);
    #1 mon_on = 1;
    for (int g = 0; g < 20000 && exp_q.size() > 0; g++) @(negedge clk);
    check(exp_q.size() == 0, "R4 scoreboard drained", exp_q.size(), 0);
    mon_on = 0;
  endtask

  // restart latency: write at an arbitrary phase, count edges to first tick
  task automatic restart_probe(input int wait_cyc, input int dv, input int pre);
    int n;
    int p;
    p = pre ? 4 : 1;
    repeat (wait_cyc) @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'd0; wr_data = dv[7:0];
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    n = 0;
    for (int g = 0; g < 200; g++) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (sample_tick) break;
    end
    check(n == 1 + p * dv, "R9 restart latency", n, 1 + p * dv);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      check(0, "watchdog", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int cnt;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      check(d == 8'h00, "R1 reset register", d, 0);
    end
    check(div_nonzero == 1'b0, "R1 div_nonzero at reset", div_nonzero, 0);
    cnt = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (sample_tick || bit_tick) cnt++;
    end
    check(cnt == 0, "R1 no ticks at reset", cnt, 0);

    // R4 plain integer divisor, 16x
    run_cfg(5, 0, 8'h00, 0, 16, 40);
    check(div_nonzero == 1'b1, "R8 div_nonzero set", div_nonzero, 1);
    rd(2'd0, d); check(d == 8'd5, "R2 low byte readback", d, 5);

    // R5 fraction, 8x
    run_cfg(3, 5, 8'h15, 0, 8, 40);
    rd(2'd2, d); check(d == 8'h15, "R2 frac/select readback", d, 8'h15);

    // R6 prescale by 4, fraction 15, 4x, reserved bits written as ones (R3)
    run_cfg(2, 15, 8'hEF, 1, 4, 32);
    rd(2'd2, d); check(d == 8'h2F, "R3 reserved bits read zero", d, 8'h2F);
    rd(2'd3, d); check(d == 8'h01, "R2 prescaler readback", d, 1);

    // R2 high byte matters: divisor 258
    run_cfg(258, 3, 8'h03, 0, 16, 8);
    rd(2'd1, d); check(d == 8'h01, "R2 high byte readback", d, 1);
    rd(2'd0, d); check(d == 8'h02, "R2 low byte of 258", d, 2);

    // R7 select 11 behaves as 4x, divisor 1 with half fraction
    run_cfg(1, 8, 8'h38, 0, 4, 40);

    // R9 restart from different phases
    run_cfg(4, 0, 8'h00, 0, 16, 4);
    restart_probe(3, 4, 0);
    restart_probe(6, 4, 0);
    run_cfg(3, 0, 8'h00, 1, 16, 4);
    restart_probe(5, 3, 1);
    restart_probe(2, 3, 1);

    // R8 zero divisor halts ticks
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h00);
    repeat (3) @(negedge clk);
    check(div_nonzero == 1'b0, "R8 div_nonzero cleared", div_nonzero, 0);
    cnt = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (sample_tick || bit_tick) cnt++;
    end
    check(cnt == 0, "R8 no ticks with zero divisor", cnt, 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule